// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry-Out

This combinational unit reshapes the second operand of an arithmetic or logic stage. It takes a data word, a shift amount, a shift-kind code and the current carry flag, and returns the shifted word together with a carry-out that flag logic can use. Five shift kinds are supported. Left shifts fill with zeros. Logical right shifts fill with zeros. Arithmetic right shifts copy the sign bit into the vacated positions. A rotate right feeds the bits that leave the bottom back in at the top. An extended rotate moves the word right by one place through the carry flag, as if the word and the carry were one 33-bit value.

The shift amount is an immediate of $clog2(WIDTH) bits, so the largest shift is WIDTH-1. A zero amount on any kind except the extended rotate returns the word unchanged and returns the incoming carry as the carry-out. The two reserved kind codes do the same for every amount.

Top module: `shf_operand_shifter`

## Requirements
- R1: Kind code 0 (logical left) shifts `shf_din` left by `shf_amt` places and fills the vacated low bits with zeros.
- R2: Kind code 1 (arithmetic left) gives the same result and the same carry-out as kind code 0 for every input.
- R3: Kind code 2 (logical right) shifts right by `shf_amt` places and fills the vacated high bits with zeros.
- R4: Kind code 3 (arithmetic right) shifts right by `shf_amt` places and fills the vacated high bits with copies of `shf_din[WIDTH-1]`.
- R5: Kind code 4 (rotate right) shifts right by `shf_amt` places, and each bit that leaves bit 0 enters at bit WIDTH-1.
- R6: Kind code 5 (extended rotate) returns `{shf_cin, shf_din[WIDTH-1:1]}`, whatever the value of `shf_amt`.
- R7: For kind code 5 the carry-out equals `shf_din[0]`, whatever the value of `shf_amt`.
- R8: For kind codes 0 to 4 with a nonzero amount, the carry-out is the last bit shifted out. For left shifts this is `shf_din[WIDTH-amt]`. For right shifts and rotates it is `shf_din[amt-1]`.
- R9: For kind codes 0 to 4 with `shf_amt` equal to 0, the output equals `shf_din` and the carry-out equals `shf_cin`.
- R10: Kind codes 6 and 7 are reserved. For any amount they return `shf_din` unchanged, with the carry-out equal to `shf_cin`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| shf_din | input | WIDTH | Word to be shifted |
| shf_amt | input | $clog2(WIDTH) | Shift amount, 0 to WIDTH-1 |
| shf_kind | input | 3 | Shift kind code (0 LSL, 1 ASL, 2 LSR, 3 ASR, 4 ROR, 5 extended rotate, 6-7 reserved) |
| shf_cin | input | 1 | Current carry flag |
| shf_dout | output | WIDTH | Shifted word |
| shf_cout | output | 1 | Shifter carry-out |

## Verification
Each kind is applied to words whose set bits sit at the two ends: `0x80000001`, a lone sign bit, and a lone bit 0. With these words, zero fill, sign fill and wrap-around each give a different result, and the carry-out shows whether the correct edge bit was picked. The amounts include 1, powers of two that stress one barrel stage each, and the extremes 0 and 31. The extremes separate pass-through from a true shift, and at 31 the left shift and the right shift carry out from opposite ends. The extended rotate is driven with both carry values and with nonzero amounts, to show that the amount has no effect. The reserved codes are driven with a nonzero amount.

// File: rtl/shf_pkg.sv
package shf_pkg;

  typedef enum logic [2:0] {
    SHF_LSL  = 3'd0,
    SHF_ASL  = 3'd1,
    SHF_LSR  = 3'd2,
    SHF_ASR  = 3'd3,
    SHF_ROR  = 3'd4,
    SHF_RRX  = 3'd5,
    SHF_RSV6 = 3'd6,
    SHF_RSV7 = 3'd7
  } shf_kind_e;

endpackage

// File: rtl/shf_left.sv
module shf_left #(
  parameter int WIDTH = 32,
  localparam int AMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] din,
  input  logic [AMT_W-1:0] amt,
  output logic [WIDTH-1:0] dout,
  output logic             last_out
);

  // Bit that leaves the top on the final step of a nonzero shift.
  function automatic logic pick_last(input logic [WIDTH-1:0] v, input logic [AMT_W-1:0] n);
    logic [AMT_W:0] pos;
    pos = AMT_W'(WIDTH) - {1'b0, n};
    return v[pos[AMT_W-1:0]];
  endfunction

  logic [WIDTH-1:0] stg [AMT_W+1];

  assign stg[0] = din;

  for (genvar s = 0; s < AMT_W; s++) begin : g_stage
    localparam int SH = 2 ** s;
    assign stg[s+1] = amt[s] ? {stg[s][WIDTH-SH-1:0], {SH{1'b0}}} : stg[s];
  end

  assign dout     = stg[AMT_W];
  assign last_out = pick_last(din, amt);

endmodule

// File: rtl/shf_right.sv
module shf_right #(
  parameter int WIDTH = 32,
  localparam int AMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] din,
  input  logic [AMT_W-1:0] amt,
  input  logic             arith,
  input  logic             rotate,
  output logic [WIDTH-1:0] dout,
  output logic             last_out
);

  // Bit that leaves bit 0 on the final step of a nonzero shift.
  function automatic logic pick_last(input logic [WIDTH-1:0] v, input logic [AMT_W-1:0] n);
    logic [AMT_W-1:0] pos;
    pos = n - 1'b1;
    return v[pos];
  endfunction

  logic             sign;
  logic [WIDTH-1:0] stg [AMT_W+1];

  assign sign   = din[WIDTH-1];
  assign stg[0] = din;

  for (genvar s = 0; s < AMT_W; s++) begin : g_stage
    localparam int SH = 2 ** s;
    logic [SH-1:0] fill;
    always_comb begin
      if (rotate)     fill = stg[s][SH-1:0];
      else if (arith) fill = {SH{sign}};
      else            fill = '0;
    end
    assign stg[s+1] = amt[s] ? {fill, stg[s][WIDTH-1:SH]} : stg[s];
  end

  assign dout     = stg[AMT_W];
  assign last_out = pick_last(din, amt);

endmodule

// File: rtl/shf_rrx.sv
module shf_rrx #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] din,
  input  logic             cin,
  output logic [WIDTH-1:0] dout,
  output logic             cout
);

  assign dout = {cin, din[WIDTH-1:1]};
  assign cout = din[0];

endmodule

// File: rtl/shf_operand_shifter.sv
module shf_operand_shifter #(
  parameter int WIDTH = 32,
  localparam int AMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] shf_din,
  input  logic [AMT_W-1:0] shf_amt,
  input  logic [2:0]       shf_kind,
  input  logic             shf_cin,
  output logic [WIDTH-1:0] shf_dout,
  output logic             shf_cout
);
  import shf_pkg::*;

  shf_kind_e        kind;
  logic             amt_is_zero;
  logic             use_rrx;
  logic             kind_reserved;
  logic             right_arith;
  logic             right_rot;

  logic [WIDTH-1:0] left_res,  right_res, rrx_res;
  logic             left_c,    right_c,   rrx_c;

  assign kind          = shf_kind_e'(shf_kind);
  assign amt_is_zero   = (shf_amt == '0);
  assign use_rrx       = (kind == SHF_RRX);
  assign kind_reserved = (kind == SHF_RSV6) || (kind == SHF_RSV7);
  assign right_arith   = (kind == SHF_ASR);
  assign right_rot     = (kind == SHF_ROR);

  shf_left #(.WIDTH(WIDTH)) u_left (
    .din      (shf_din),
    .amt      (shf_amt),
    .dout     (left_res),
    .last_out (left_c)
  );

  shf_right #(.WIDTH(WIDTH)) u_right (
    .din      (shf_din),
    .amt      (shf_amt),
    .arith    (right_arith),
    .rotate   (right_rot),
    .dout     (right_res),
    .last_out (right_c)
  );

  shf_rrx #(.WIDTH(WIDTH)) u_rrx (
    .din  (shf_din),
    .cin  (shf_cin),
    .dout (rrx_res),
    .cout (rrx_c)
  );

  always_comb begin
    unique case (kind)
      SHF_LSL, SHF_ASL: begin
        shf_dout = left_res;
        shf_cout = left_c;
      end
      SHF_LSR, SHF_ASR, SHF_ROR: begin
        shf_dout = right_res;
        shf_cout = right_c;
      end
      SHF_RRX: begin
        shf_dout = rrx_res;
        shf_cout = rrx_c;
      end
      default: begin
        shf_dout = shf_din;
        shf_cout = shf_cin;
      end
    endcase
    if (amt_is_zero && !use_rrx) begin
      shf_dout = shf_din;
      shf_cout = shf_cin;
    end
  end

endmodule

// File: rtl/shf_operand_shifter_chk.sv
module shf_operand_shifter_chk #(
  parameter int WIDTH = 32,
  localparam int AMT_W = $clog2(WIDTH)
) (
  input logic [WIDTH-1:0] din,
  input logic [AMT_W-1:0] amt,
  input logic [2:0]       kind,
  input logic             cin,
  input logic [WIDTH-1:0] dout,
  input logic             cout,
  input logic             amt_is_zero,
  input logic             use_rrx,
  input logic             kind_reserved
);

  logic [WIDTH-1:0] lo_mask;
  assign lo_mask = (WIDTH'(1) << amt) - WIDTH'(1);

  always_comb begin
    if (kind == 3'd0 || kind == 3'd1)
      assert_left_zero_fill_R1: assert ((dout & lo_mask) == '0)
        else $error("left shift low bits not zero");
    if (kind == 3'd2 && !amt_is_zero)
      assert_lsr_top_clear_R3: assert (dout[WIDTH-1] == 1'b0)
        else $error("logical right top bit set");
    if (kind == 3'd3)
      assert_asr_sign_kept_R4: assert (dout[WIDTH-1] == din[WIDTH-1])
        else $error("arithmetic right sign lost");
    if (kind == 3'd4)
      assert_ror_bits_kept_R5: assert ($countones(dout) == $countones(din))
        else $error("rotate changed bit count");
    if (use_rrx) begin
      assert_rrx_carry_in_top_R6: assert (dout[WIDTH-1] == cin)
        else $error("extended rotate top bit wrong");
      assert_rrx_carry_out_R7: assert (cout == din[0])
        else $error("extended rotate carry wrong");
    end
    if (amt_is_zero && !use_rrx)
      assert_zero_amt_pass_R9: assert (dout == din && cout == cin)
        else $error("zero amount not pass-through");
    if (kind_reserved)
      assert_reserved_pass_R10: assert (dout == din && cout == cin)
        else $error("reserved kind not pass-through");
  end

endmodule

bind shf_operand_shifter shf_operand_shifter_chk #(.WIDTH(WIDTH)) u_chk (
  .din           (shf_din),
  .amt           (shf_amt),
  .kind          (shf_kind),
  .cin           (shf_cin),
  .dout          (shf_dout),
  .cout          (shf_cout),
  .amt_is_zero   (amt_is_zero),
  .use_rrx       (use_rrx),
  .kind_reserved (kind_reserved)
);

// File: tb/sim_shf_operand_shifter.sv
module sim_shf_operand_shifter;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int NVEC = 14;

  // stimulus: {din, amt, kind, cin}
  localparam logic [40:0] VEC [NVEC] = '{
    {32'h8000_0001, 5'd1,  3'd0, 1'b0},
    {32'h8000_0001, 5'd1,  3'd1, 1'b0},
    {32'h1234_5678, 5'd8,  3'd0, 1'b1},
    {32'h1234_5678, 5'd8,  3'd1, 1'b1},
    {32'h8000_0001, 5'd16, 3'd2, 1'b0},
    {32'hF0F0_0F0F, 5'd4,  3'd2, 1'b1},
    {32'h8000_0000, 5'd2,  3'd3, 1'b0},
    {32'h7FFF_FFFF, 5'd31, 3'd3, 1'b1},
    {32'hF0F0_0F0F, 5'd3,  3'd3, 1'b0},
    {32'h0000_0001, 5'd1,  3'd4, 1'b0},
    {32'hDEAD_BEEF, 5'd12, 3'd4, 1'b1},
    {32'hDEAD_BEEF, 5'd31, 3'd4, 1'b0},
    {32'h0000_0003, 5'd31, 3'd0, 1'b0},
    {32'h8000_0000, 5'd31, 3'd2, 1'b1}
  };

  logic          clk = 1'b0;
  logic [W-1:0]  din = '0;
  logic [4:0]    amt = '0;
  logic [2:0]    kind = '0;
  logic          cin = 1'b0;
  logic [W-1:0]  dout;
  logic          cout;
  int            checks = 0;
  int            failures = 0;
  bit            done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shf_operand_shifter #(.WIDTH(W)) u0 (
    .shf_din  (din),
    .shf_amt  (amt),
    .shf_kind (kind),
    .shf_cin  (cin),
    .shf_dout (dout),
    .shf_cout (cout)
  );

  // Independent bit-by-bit model.
  function automatic logic [W:0] model(input logic [W-1:0] x, input int n, input int k, input logic c);
    logic [W-1:0] r;
    logic         co;
    r = x; co = c;
    if (k == 5) begin
      for (int i = 0; i < W - 1; i++) r[i] = x[i+1];
      r[W-1] = c; co = x[0];
    end else if (k <= 4 && n != 0) begin
      for (int i = 0; i < W; i++) begin
        if (k <= 1)      r[i] = (i - n >= 0) ? x[i-n] : 1'b0;
        else if (k == 4) r[i] = x[(i+n) % W];
        else if (i + n < W) r[i] = x[i+n];
        else             r[i] = (k == 3) ? x[W-1] : 1'b0;
      end
      co = (k <= 1) ? x[W-n] : x[n-1];
    end
    return {co, r};
  endfunction

  task automatic check(input string req, input logic [W-1:0] ed, input logic ec);
    checks++;
    if (dout !== ed || cout !== ec) begin
      failures++;
      $display("FAIL %s: din=%h amt=%0d kind=%0d cin=%b got dout=%h cout=%b expected dout=%h cout=%b",
               req, din, amt, kind, cin, dout, cout, ed, ec);
    end
  endtask

  task automatic apply(input logic [W-1:0] d, input logic [4:0] a, input logic [2:0] k, input logic c);
    @(negedge clk);
    din = d; amt = a; kind = k; cin = c;
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    logic [W:0] e;
    // reset-state check: all-zero inputs give zero outputs
    #1;
    check("R9", '0, 1'b0);

    // table walk against model (R1 R2 R3 R4 R5 R8)
    for (int v = 0; v < NVEC; v++) begin
      apply(VEC[v][40:9], VEC[v][8:4], VEC[v][3:1], VEC[v][0]);
      e = model(din, int'(amt), int'(kind), cin);
      case (kind)
        3'd0:    check("R1/R8", e[W-1:0], e[W]);
        3'd1:    check("R2/R8", e[W-1:0], e[W]);
        3'd2:    check("R3/R8", e[W-1:0], e[W]);
        3'd3:    check("R4/R8", e[W-1:0], e[W]);
        default: check("R5/R8", e[W-1:0], e[W]);
      endcase
    end

    // directed corner cases
    apply(32'h8000_0001, 5'd1, 3'd0, 1'b0);  check("R1", 32'h0000_0002, 1'b1);
    apply(32'h8000_0001, 5'd1, 3'd1, 1'b0);  check("R2", 32'h0000_0002, 1'b1);
    apply(32'h8000_0001, 5'd1, 3'd2, 1'b0);  check("R3", 32'h4000_0000, 1'b1);
    apply(32'h8000_0000, 5'd4, 3'd3, 1'b1);  check("R4", 32'hF800_0000, 1'b0);
    apply(32'h8000_0000, 5'd31, 3'd3, 1'b1); check("R4", 32'hFFFF_FFFF, 1'b0);
    apply(32'h0000_0001, 5'd1, 3'd4, 1'b0);  check("R5", 32'h8000_0000, 1'b1);
    apply(32'h0000_0003, 5'd31, 3'd0, 1'b0); check("R8", 32'h8000_0000, 1'b1);
    apply(32'h0000_0003, 5'd0, 3'd5, 1'b1);  check("R6", 32'h8000_0001, 1'b1);
    apply(32'h0000_0003, 5'd7, 3'd5, 1'b1);  check("R6", 32'h8000_0001, 1'b1);
    apply(32'h0000_0002, 5'd19, 3'd5, 1'b0); check("R7", 32'h0000_0001, 1'b0);
    apply(32'hFFFF_FFFF, 5'd1, 3'd5, 1'b0);  check("R7", 32'h7FFF_FFFF, 1'b1);
    apply(32'h0000_1234, 5'd0, 3'd0, 1'b1);  check("R9", 32'h0000_1234, 1'b1);
    apply(32'h8765_4321, 5'd0, 3'd3, 1'b0);  check("R9", 32'h8765_4321, 1'b0);
    apply(32'h8765_4321, 5'd0, 3'd4, 1'b1);  check("R9", 32'h8765_4321, 1'b1);
    apply(32'hA5A5_5A5A, 5'd5, 3'd6, 1'b1);  check("R10", 32'hA5A5_5A5A, 1'b1);
    apply(32'hA5A5_5A5A, 5'd9, 3'd7, 1'b0);  check("R10", 32'hA5A5_5A5A, 1'b0);

    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

endmodule